// File: doc/BRIEF.md
# Card Clock Divider with Mode Control

This block derives the card clock for a memory-card host from the master clock. A divide code of N (N ≥ 1) gives a card clock period of 2·N master cycles: N cycles high, then N cycles low. A code of zero passes the master clock straight through. The code comes either from a direct input or from a requested rate, which is turned into the smallest code that does not overshoot that rate. Double-data-rate operation cannot use the pass-through, so it is promoted to the smallest real divider. A new code is loaded only when the card clock rises, so no runt pulse is ever produced.

Alongside the clock, the block produces three single-cycle strobes in the master clock domain. One marks each card-clock rise, one marks each fall, and a data strobe marks every edge on which the data path should move. It also registers a small group of mode controls: the lane-count field, a high-speed flag, the feedback-clock select and the flow-control enable. While power is off, the card clock is held low. A requested rate of zero does not stop the clock; it selects the slowest divider.

Top module: `ckdiv_top`

## Requirements
- R1: With an active code N ≥ 1, the card clock period is 2·N master cycles, with exactly N cycles high. Rise and fall strobes never occur in the same cycle, and each rise strobe coincides with the card clock being high.
- R2: With an active code of 0, the card clock is the master clock and a rise strobe appears in every master cycle, giving a period of 1 and one data strobe per period.
- R3: When double-data-rate mode is set, a selected code of 0 is replaced by 1 (period of 2 master cycles). The active code is never 0 while double-data-rate mode is in effect.
- R4: A change of the selected code or of the double-data-rate flag takes effect only at the next card-clock rise. The period running when the change is made completes with the old code.
- R5: In double-data-rate mode, the data strobe fires on both the rise and the fall strobe (two per period). Otherwise it fires on the rise strobe only (one per period).
- R6: With `req_sel`=1, the code is the smallest c with 2·c·`req_rate` ≥ `mclk_rate`, saturated at the all-ones code. If `req_rate` ≥ `mclk_rate` and double-data-rate mode is off, the code is 0 (pass-through).
- R7: With `req_sel`=1 and `req_rate`=0, the maximum code (all ones) is selected and the clock keeps running.
- R8: While `pwr_on` is 0, the card clock is low and no rise, fall or data strobe is produced, starting from the first edge after it falls.
- R9: `bus_field` is registered one cycle after `width_sel`. The encoding is 00 for one data line, 01 for four and 10 for eight; the unused selection 11 maps to 00.
- R10: One cycle after `timing_cls`, `speed_hi` is 1 for classes 4 to 7, `fb_sel` is 1 only for classes 6 and 7, and `hwfc_out` follows `hwfc_en`. The class encoding is 0 default-speed, 1 high-speed, 2 SDR12, 3 SDR25, 4 SDR50, 5 DDR50, 6 SDR104, 7 HS200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Card power on; 0 stops the card clock |
| req_sel | input | 1 | 1: code from requested rate, 0: direct code |
| div_code | input | DIV_W | Direct divide code (0 = pass-through) |
| mclk_rate | input | RATE_W | Master clock rate, any unit |
| req_rate | input | RATE_W | Requested card rate, same unit |
| ddr_en | input | 1 | Double-data-rate mode request |
| width_sel | input | 2 | Lane count selection |
| timing_cls | input | 3 | Bus timing class |
| hwfc_en | input | 1 | Hardware flow-control enable |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | Card-clock rising-edge strobe |
| fall_stb | output | 1 | Card-clock falling-edge strobe |
| data_stb | output | 1 | Data-path edge strobe |
| bus_field | output | 2 | Registered lane-count field |
| speed_hi | output | 1 | High-speed class flag |
| fb_sel | output | 1 | Feedback clock select |
| hwfc_out | output | 1 | Registered flow-control enable |

## Verification
The assertions assume that reset is applied before any checked cycle. They also assume that `pwr_on`, the code inputs and the mode inputs change only between master-clock edges, because the active code and the double-data-rate flag are loaded at a rise without any synchronizer. The stimulus drives every input on the falling master edge and changes the code only right after an observed rise strobe. This gives each change a known old period to complete, which the bench measures. The rate inputs stay small enough that the rounded quotient fits the internal quotient width.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  typedef enum logic [2:0] {
    TC_DS     = 3'd0,
    TC_HS     = 3'd1,
    TC_SDR12  = 3'd2,
    TC_SDR25  = 3'd3,
    TC_SDR50  = 3'd4,
    TC_DDR50  = 3'd5,
    TC_SDR104 = 3'd6,
    TC_HS200  = 3'd7
  } tclass_e;

  typedef enum logic [1:0] {
    LANES_1 = 2'b00,
    LANES_4 = 2'b01,
    LANES_8 = 2'b10
  } lanes_e;

  typedef struct packed {
    lanes_e lanes;
    logic   speed_hi;
    logic   fb_sel;
    logic   hwfc;
  } mode_t;

  function automatic lanes_e lanes_decode(input logic [1:0] sel);
    case (sel)
      2'b01:   return LANES_4;
      2'b10:   return LANES_8;
      default: return LANES_1;
    endcase
  endfunction

  function automatic logic is_fast_class(input tclass_e tc);
    return (tc >= TC_SDR50);
  endfunction

  function automatic logic needs_feedback(input tclass_e tc);
    return (tc == TC_SDR104) || (tc == TC_HS200);
  endfunction
endpackage

// File: rtl/ckdiv_code_sel.sv
module ckdiv_code_sel #(
  parameter int DIV_W  = 8,
  parameter int RATE_W = 16
) (
  input  logic              req_sel,
  input  logic [DIV_W-1:0]  div_code,
  input  logic [RATE_W-1:0] mclk_rate,
  input  logic [RATE_W-1:0] req_rate,
  input  logic              ddr_en,
  output logic [DIV_W-1:0]  nxt_code
);
  localparam int QW = RATE_W + 2;
  localparam logic [DIV_W-1:0] CODE_MAX = '1;

  // rounded-up quotient mclk / (2*req), saturated; pass-through when fast enough
  function automatic logic [DIV_W-1:0] rate_to_code(
    input logic [RATE_W-1:0] m,
    input logic [RATE_W-1:0] r,
    input logic              ddr
  );
    logic [QW-1:0] den;
    logic [QW-1:0] num;
    logic [QW-1:0] q;
    if (r == '0) return CODE_MAX;
    if ((r >= m) && !ddr) return '0;
    den = {1'b0, r, 1'b0};
    num = {2'b00, m} + den - QW'(1);
    q   = num / den;
    if (q > QW'(CODE_MAX)) return CODE_MAX;
    if (q == '0) return DIV_W'(1);
    return q[DIV_W-1:0];
  endfunction

  function automatic logic [DIV_W-1:0] ddr_guard(
    input logic [DIV_W-1:0] code,
    input logic             ddr
  );
    return (ddr && (code == '0)) ? DIV_W'(1) : code;
  endfunction

  logic [DIV_W-1:0] raw_code;
  assign raw_code = req_sel ? rate_to_code(mclk_rate, req_rate, ddr_en) : div_code;
  assign nxt_code = ddr_guard(raw_code, ddr_en);
endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
  parameter int DIV_W    = 8,
  parameter int RST_CODE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic [DIV_W-1:0] nxt_code,
  input  logic             ddr_in,
  output logic [DIV_W-1:0] act_code,
  output logic             ddr_q,
  output logic             ck_div,
  output logic             bypass,
  output logic             load_evt,
  output logic             rise_q,
  output logic             fall_q
);
  logic [DIV_W-1:0] cnt;
  logic             phase_end;

  assign bypass    = (act_code == '0);
  assign phase_end = !bypass && (cnt == act_code - 1'b1);
  assign load_evt  = pwr_on && (bypass || (phase_end && !ck_div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      ck_div   <= 1'b0;
      act_code <= DIV_W'(RST_CODE);
      ddr_q    <= 1'b0;
      rise_q   <= 1'b0;
      fall_q   <= 1'b0;
    end else if (!pwr_on) begin
      cnt    <= '0;
      ck_div <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (load_evt) begin
        act_code <= nxt_code;
        ddr_q    <= ddr_in;
      end
      if (bypass) begin
        rise_q <= 1'b1;
        cnt    <= '0;
        ck_div <= (nxt_code != '0);
      end else if (phase_end) begin
        cnt    <= '0;
        ck_div <= !ck_div;
        if (!ck_div) rise_q <= 1'b1;
        else         fall_q <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ckdiv_mode.sv
module ckdiv_mode
  import ckdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] width_sel,
  input  logic [2:0] timing_cls,
  input  logic       hwfc_en,
  output mode_t      mode_q
);
  mode_t  mode_d;
  tclass_e tc;

  assign tc = tclass_e'(timing_cls);

  always_comb begin
    mode_d.lanes    = lanes_decode(width_sel);
    mode_d.speed_hi = is_fast_class(tc);
    mode_d.fb_sel   = needs_feedback(tc);
    mode_d.hwfc     = hwfc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{lanes: LANES_1, speed_hi: 1'b0, fb_sel: 1'b0, hwfc: 1'b0};
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top
  import ckdiv_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int RATE_W   = 16,
  parameter int RST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              req_sel,
  input  logic [DIV_W-1:0]  div_code,
  input  logic [RATE_W-1:0] mclk_rate,
  input  logic [RATE_W-1:0] req_rate,
  input  logic              ddr_en,
  input  logic [1:0]        width_sel,
  input  logic [2:0]        timing_cls,
  input  logic              hwfc_en,
  output logic              card_clk,
  output logic              rise_stb,
  output logic              fall_stb,
  output logic              data_stb,
  output logic [1:0]        bus_field,
  output logic              speed_hi,
  output logic              fb_sel,
  output logic              hwfc_out
);
  logic [DIV_W-1:0] nxt_code;
  logic [DIV_W-1:0] act_code;
  logic             ddr_q;
  logic             ck_div;
  logic             bypass;
  logic             load_evt;
  mode_t            mode_q;

  ckdiv_code_sel #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_sel (
    .req_sel   (req_sel),
    .div_code  (div_code),
    .mclk_rate (mclk_rate),
    .req_rate  (req_rate),
    .ddr_en    (ddr_en),
    .nxt_code  (nxt_code)
  );

  ckdiv_gen #(.DIV_W(DIV_W), .RST_CODE(RST_CODE)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_on   (pwr_on),
    .nxt_code (nxt_code),
    .ddr_in   (ddr_en),
    .act_code (act_code),
    .ddr_q    (ddr_q),
    .ck_div   (ck_div),
    .bypass   (bypass),
    .load_evt (load_evt),
    .rise_q   (rise_stb),
    .fall_q   (fall_stb)
  );

  ckdiv_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .width_sel  (width_sel),
    .timing_cls (timing_cls),
    .hwfc_en    (hwfc_en),
    .mode_q     (mode_q)
  );

  assign card_clk  = bypass ? (clk & pwr_on) : ck_div;
  assign data_stb  = rise_stb | (ddr_q & fall_stb);
  assign bus_field = mode_q.lanes;
  assign speed_hi  = mode_q.speed_hi;
  assign fb_sel    = mode_q.fb_sel;
  assign hwfc_out  = mode_q.hwfc;
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_on,
  input logic [DIV_W-1:0] act_code,
  input logic             ddr_q,
  input logic             ck_div,
  input logic             bypass,
  input logic             load_evt,
  input logic             rise_stb,
  input logic             fall_stb,
  input logic             data_stb,
  input logic             speed_hi,
  input logic             fb_sel
);
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb)); // R1
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !bypass) |-> ck_div); // R1
  AST_BYPASS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && pwr_on) |=> rise_stb); // R2
  AST_DDR_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_q |-> (act_code != '0)); // R3
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(act_code)); // R4
  AST_SDR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && !ddr_q) |-> !data_stb); // R5
  AST_PWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (!rise_stb && !fall_stb && !data_stb)); // R8
  AST_FB_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    fb_sel |-> speed_hi); // R10
endmodule

bind ckdiv_top ckdiv_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_on   (pwr_on),
  .act_code (act_code),
  .ddr_q    (ddr_q),
  .ck_div   (ck_div),
  .bypass   (bypass),
  .load_evt (load_evt),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb),
  .data_stb (data_stb),
  .speed_hi (speed_hi),
  .fb_sel   (fb_sel)
);

// File: tb/tb_ckdiv_top.sv
`timescale 1ns/1ps
module tb_ckdiv_top;
  localparam int DIV_W  = 8;
  localparam int RATE_W = 16;
  localparam int MAXC   = (1 << DIV_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0;
  logic req_sel = 1'b0;
  logic [DIV_W-1:0] div_code = '0;
  logic [RATE_W-1:0] mclk_rate = '0;
  logic [RATE_W-1:0] req_rate = '0;
  logic ddr_en = 1'b0;
  logic [1:0] width_sel = 2'b00;
  logic [2:0] timing_cls = 3'd0;
  logic hwfc_en = 1'b0;
  logic card_clk, rise_stb, fall_stb, data_stb, speed_hi, fb_sel, hwfc_out;
  logic [1:0] bus_field;

  always #2.5 clk = ~clk;

  ckdiv_top #(.DIV_W(DIV_W), .RATE_W(RATE_W), .RST_CODE(1)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .req_sel(req_sel),
    .div_code(div_code), .mclk_rate(mclk_rate), .req_rate(req_rate),
    .ddr_en(ddr_en), .width_sel(width_sel), .timing_cls(timing_cls),
    .hwfc_en(hwfc_en), .card_clk(card_clk), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .data_stb(data_stb), .bus_field(bus_field),
    .speed_hi(speed_hi), .fb_sel(fb_sel), .hwfc_out(hwfc_out)
  );

  typedef struct {
    int    per;
    int    hi;
    int    dat;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   active = 0;
  bit   arm_req = 0;
  int   cur_n = -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected code restated from the requirements: search for the smallest c
  function automatic int exp_code(input bit rsel, input int code, input bit ddr,
                                  input int m, input int r);
    int c;
    if (!rsel) c = code;
    else if (r == 0) c = MAXC;
    else if (r >= m && !ddr) c = 0;
    else begin
      c = MAXC;
      for (int k = 1; k <= MAXC; k++) begin
        if (2 * k * r >= m) begin c = k; break; end
      end
    end
    if (ddr && c == 0) c = 1;
    return c;
  endfunction

  task automatic wait_rise();
    do @(negedge clk); while (!rise_stb);
  endtask

  // monitor: measures each card-clock period and compares with the queue
  initial begin
    int cyc = 0, hi = 0, dat = 0;
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (arm_req) begin
        arm_req = 0; active = 1; cyc = 0; hi = 0; dat = 0;
      end else if (active) begin
        cyc++;
        if (card_clk) hi++;
        if (data_stb) dat++;
        if (rise_stb) begin
          if (exp_q.size() == 0) active = 0;
          else begin
            e = exp_q.pop_front();
            chk(cyc == e.per, e.req, "period", cyc, e.per);
            chk(hi == e.hi, e.req, "high samples", hi, e.hi);
            chk(dat == e.dat, "R5", "data strobes", dat, e.dat);
          end
          cyc = 0; hi = 0; dat = 0;
        end
      end
    end
  end

  // driver: change settings right after a rise, check the old period (R4), queue new ones
  task automatic apply_cfg(input bit rsel, input int code, input bit ddr,
                           input int m, input int r, input int k, input string req);
    int n, cnt;
    exp_t e;
    wait_rise();
    active = 0;
    req_sel = rsel; div_code = DIV_W'(code); ddr_en = ddr;
    mclk_rate = RATE_W'(m); req_rate = RATE_W'(r);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rise_stb);
    if (cur_n >= 0)
      chk(cnt == ((cur_n == 0) ? 1 : 2 * cur_n), "R4", "old period after change",
          cnt, (cur_n == 0) ? 1 : 2 * cur_n);
    n = exp_code(rsel, code, ddr, m, r);
    for (int i = 0; i < k; i++) begin
      e.per = (n == 0) ? 1 : 2 * n;
      e.hi  = (n == 0) ? 0 : n;
      e.dat = (n != 0 && ddr) ? 2 : 1;
      e.req = req;
      exp_q.push_back(e);
    end
    arm_req = 1;
    cur_n = n;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(card_clk == 0 && rise_stb == 0 && fall_stb == 0 && data_stb == 0,
        "R8", "outputs in reset", {card_clk, rise_stb, fall_stb, data_stb}, 0);
    chk(bus_field == 0 && speed_hi == 0 && fb_sel == 0 && hwfc_out == 0,
        "R9", "mode outputs in reset", {bus_field, speed_hi, fb_sel, hwfc_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    pwr_on = 1'b1;

    apply_cfg(0, 3, 0, 0, 0, 3, "R1");          // divide by 6
    apply_cfg(0, 3, 1, 0, 0, 3, "R5");          // same code, both edges
    apply_cfg(0, 0, 0, 0, 0, 5, "R2");          // pass-through
    apply_cfg(0, 0, 1, 0, 0, 3, "R3");          // DDR promotes to 1
    apply_cfg(0, 5, 0, 0, 0, 3, "R1");
    apply_cfg(1, 0, 0, 1000, 90, 3, "R6");      // rounds up to 6
    apply_cfg(1, 0, 0, 1000, 1, 2, "R6");       // saturates at 255
    apply_cfg(1, 0, 0, 1000, 0, 1, "R7");       // zero rate -> maximum
    apply_cfg(1, 0, 0, 1000, 1200, 3, "R6");    // fast enough -> pass-through
    apply_cfg(1, 0, 1, 1000, 1200, 3, "R3");    // DDR cannot pass through

    // R8: power off stops the clock and the strobes
    wait_rise();
    active = 0;
    pwr_on = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (card_clk || rise_stb || fall_stb || data_stb) seen++;
      end
      chk(seen == 0, "R8", "active samples while off", seen, 0);
    end
    pwr_on = 1'b1;
    cur_n = -1;
    apply_cfg(0, 2, 0, 0, 0, 3, "R1");

    // R9: lane-count field
    for (int w = 0; w < 4; w++) begin
      width_sel = 2'(w);
      @(negedge clk);
      chk(bus_field == ((w == 3) ? 0 : w), "R9", "bus_field", bus_field,
          (w == 3) ? 0 : w);
    end
    // R10: class decode and flow-control pass-through
    for (int t = 0; t < 8; t++) begin
      timing_cls = 3'(t);
      hwfc_en = t[0];
      @(negedge clk);
      chk(speed_hi == (t >= 4), "R10", "speed_hi", speed_hi, (t >= 4));
      chk(fb_sel == (t >= 6), "R10", "fb_sel", fb_sel, (t >= 6));
      chk(hwfc_out == t[0], "R10", "hwfc_out", hwfc_out, t[0]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule